// File: doc/BRIEF.md
# Execute-Stage Operand Forwarding Unit

This block sits between the pipeline registers of a five-stage in-order processor. It chooses where each ALU operand in the execute stage comes from. The choice is between three values: the one read at decode, the result now in the memory stage, and the result now in the writeback stage. For each operand it compares the operand's source register number with the destination register numbers of the two instructions ahead of it. A match counts only if that instruction writes a register and the register is not register zero. When both instructions match, the newer result, in the memory stage, wins.

A second, narrower path serves a branch comparator in the decode stage. The memory-stage result is forwarded to either comparator input whose register it produces. No writeback path is offered there, because the register file writes in the first half of a cycle and reads in the second. The select signals are combinational. A small demonstration datapath applies them to four operand multiplexers, one for each ALU input and one for each comparator input. Each multiplexer feeds a register with a synchronous active-high reset, so the chosen values appear one clock after the selects.

Top module: `fwd_unit_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, all four registered operand outputs (`opnd_a`, `opnd_b`, `cmp_a`, `cmp_b`) become zero after that edge.
- R2: The ALU operand selects use this encoding: 2'b00 takes the value read at decode, 2'b10 takes the memory-stage result and 2'b01 takes the writeback-stage result. 2'b11 is never produced. The selected value appears on the matching operand output after the next rising clock edge.
- R3: A stage forwards only when its write flag is high and its destination number equals the operand's source number. A matching destination with the write flag low gives no forward from that stage.
- R4: A destination of register 0 is never forwarded from either stage. An operand whose only match is register 0 keeps select 2'b00.
- R5: When both stages would forward to the same operand, the select is 2'b10 (memory stage). The writeback stage is chosen only if the memory stage does not match or does not write.
- R6: Operand A is compared with the `ex_rs` source and operand B with the `ex_rt` source. Each is decided on its own, so both may forward in the same cycle, from the same stage or from different stages.
- R7: `sel_c` (or `sel_d`) is 1 only when `id_branch` is high, `em_rd` is nonzero and `em_rd` equals `id_rs` (or `id_rt`). Otherwise it is 0.
- R8: A comparator output carries `em_val` after the next clock edge when its select is 1. When its select is 0 it carries the value read at decode (`id_rs_val` or `id_rt_val`).
- R9: The writeback-stage destination and write flag have no effect on `sel_c`, `sel_d`, `cmp_a` or `cmp_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the operand registers |
| rst | input | 1 | Synchronous active-high reset |
| ex_rs | input | 5 | Source register A of the instruction in execute |
| ex_rt | input | 5 | Source register B of the instruction in execute |
| em_rd | input | 5 | Destination number in the memory-stage register |
| em_we | input | 1 | Register write flag of the memory-stage instruction |
| mw_rd | input | 5 | Destination number in the writeback-stage register |
| mw_we | input | 1 | Register write flag of the writeback-stage instruction |
| id_branch | input | 1 | Instruction in decode is a branch |
| id_rs | input | 5 | First comparator source register in decode |
| id_rt | input | 5 | Second comparator source register in decode |
| ex_rs_val | input | 32 | Operand A value read at decode |
| ex_rt_val | input | 32 | Operand B value read at decode |
| em_val | input | 32 | Result held in the memory stage |
| mw_val | input | 32 | Result held in the writeback stage |
| id_rs_val | input | 32 | First comparator value from the register file |
| id_rt_val | input | 32 | Second comparator value from the register file |
| sel_a | output | 2 | Operand A source select |
| sel_b | output | 2 | Operand B source select |
| sel_c | output | 1 | First comparator input takes memory-stage result |
| sel_d | output | 1 | Second comparator input takes memory-stage result |
| opnd_a | output | 32 | Registered operand A |
| opnd_b | output | 32 | Registered operand B |
| cmp_a | output | 32 | Registered first comparator input |
| cmp_b | output | 32 | Registered second comparator input |

## Verification
The assertions run on every cycle. They check that the select encoding stays legal, that register zero and non-writing stages never cause a forward, that a valid memory-stage match always wins, that the branch selects stay low with no branch in decode, and that each registered operand follows its select one cycle later. Some behaviour shows only in the bench's scenarios: a writeback match that loses to a newer match on the same register, two operands forwarded from different stages at once, and writeback state that cannot reach the comparator path.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int unsigned REG_W  = 5;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SRC_DX = 2'b00,
    SRC_MW = 2'b01,
    SRC_EM = 2'b10
  } opsel_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int unsigned REG_W = fwd_pkg::REG_W
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] dst,
  input  logic             wr,
  output logic             hit
);
  always_comb begin
    hit = wr && (dst != '0) && (dst == src);
  end
endmodule

// File: rtl/fwd_operand_pick.sv
module fwd_operand_pick
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W = fwd_pkg::REG_W
) (
  input  logic [REG_W-1:0] src,
  input  logic [REG_W-1:0] em_rd,
  input  logic             em_we,
  input  logic [REG_W-1:0] mw_rd,
  input  logic             mw_we,
  output opsel_e           sel
);
  logic em_hit;
  logic mw_hit;

  fwd_match #(.REG_W(REG_W)) em_match_i (
    .src(src), .dst(em_rd), .wr(em_we), .hit(em_hit)
  );

  fwd_match #(.REG_W(REG_W)) mw_match_i (
    .src(src), .dst(mw_rd), .wr(mw_we), .hit(mw_hit)
  );

  // newer result takes precedence over the older one
  always_comb begin
    if (em_hit)      sel = SRC_EM;
    else if (mw_hit) sel = SRC_MW;
    else             sel = SRC_DX;
  end
endmodule

// File: rtl/fwd_operand_reg.sv
module fwd_operand_reg
  import fwd_pkg::*;
#(
  parameter int unsigned DATA_W = fwd_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  opsel_e            sel,
  input  logic [DATA_W-1:0] dx_val,
  input  logic [DATA_W-1:0] em_val,
  input  logic [DATA_W-1:0] mw_val,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] d;

  always_comb begin
    unique case (sel)
      SRC_EM:  d = em_val;
      SRC_MW:  d = mw_val;
      default: d = dx_val;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
  import fwd_pkg::*;
#(
  parameter int unsigned REG_W  = fwd_pkg::REG_W,
  parameter int unsigned DATA_W = fwd_pkg::DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [REG_W-1:0]  ex_rs,
  input  logic [REG_W-1:0]  ex_rt,
  input  logic [REG_W-1:0]  em_rd,
  input  logic              em_we,
  input  logic [REG_W-1:0]  mw_rd,
  input  logic              mw_we,
  input  logic              id_branch,
  input  logic [REG_W-1:0]  id_rs,
  input  logic [REG_W-1:0]  id_rt,
  input  logic [DATA_W-1:0] ex_rs_val,
  input  logic [DATA_W-1:0] ex_rt_val,
  input  logic [DATA_W-1:0] em_val,
  input  logic [DATA_W-1:0] mw_val,
  input  logic [DATA_W-1:0] id_rs_val,
  input  logic [DATA_W-1:0] id_rt_val,
  output logic [1:0]        sel_a,
  output logic [1:0]        sel_b,
  output logic              sel_c,
  output logic              sel_d,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] cmp_a,
  output logic [DATA_W-1:0] cmp_b
);
  localparam int unsigned N_ALU = 2;
  localparam int unsigned N_CMP = 2;
  localparam int unsigned N_ALL = N_ALU + N_CMP;

  logic [REG_W-1:0]  alu_src  [N_ALU];
  logic [REG_W-1:0]  cmp_src  [N_CMP];
  logic              cmp_hit  [N_CMP];
  opsel_e            path_sel [N_ALL];
  logic [DATA_W-1:0] path_dx  [N_ALL];
  logic [DATA_W-1:0] path_q   [N_ALL];

  assign alu_src[0] = ex_rs;
  assign alu_src[1] = ex_rt;
  assign cmp_src[0] = id_rs;
  assign cmp_src[1] = id_rt;
  assign path_dx[0] = ex_rs_val;
  assign path_dx[1] = ex_rt_val;
  assign path_dx[2] = id_rs_val;
  assign path_dx[3] = id_rt_val;

  genvar gi;
  generate
    for (gi = 0; gi < N_ALU; gi++) begin : g_alu
      fwd_operand_pick #(.REG_W(REG_W)) pick_i (
        .src(alu_src[gi]), .em_rd(em_rd), .em_we(em_we),
        .mw_rd(mw_rd), .mw_we(mw_we), .sel(path_sel[gi])
      );
    end

    // comparator: memory-stage path only, qualified by the branch flag
    for (gi = 0; gi < N_CMP; gi++) begin : g_cmp
      fwd_match #(.REG_W(REG_W)) br_match_i (
        .src(cmp_src[gi]), .dst(em_rd), .wr(id_branch), .hit(cmp_hit[gi])
      );
      assign path_sel[N_ALU+gi] = cmp_hit[gi] ? SRC_EM : SRC_DX;
    end

    for (gi = 0; gi < N_ALL; gi++) begin : g_reg
      fwd_operand_reg #(.DATA_W(DATA_W)) reg_i (
        .clk(clk), .rst(rst), .sel(path_sel[gi]),
        .dx_val(path_dx[gi]), .em_val(em_val), .mw_val(mw_val),
        .q(path_q[gi])
      );
    end
  endgenerate

  assign sel_a  = path_sel[0];
  assign sel_b  = path_sel[1];
  assign sel_c  = cmp_hit[0];
  assign sel_d  = cmp_hit[1];
  assign opnd_a = path_q[0];
  assign opnd_b = path_q[1];
  assign cmp_a  = path_q[2];
  assign cmp_b  = path_q[3];
endmodule

// File: rtl/fwd_unit_top_chk.sv
module fwd_unit_top_chk #(
  parameter int unsigned REG_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [REG_W-1:0]  ex_rs,
  input logic [REG_W-1:0]  ex_rt,
  input logic [REG_W-1:0]  em_rd,
  input logic              em_we,
  input logic [REG_W-1:0]  mw_rd,
  input logic              mw_we,
  input logic              id_branch,
  input logic [DATA_W-1:0] em_val,
  input logic [DATA_W-1:0] mw_val,
  input logic [1:0]        sel_a,
  input logic [1:0]        sel_b,
  input logic              sel_c,
  input logic              sel_d,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (opnd_a == '0 && opnd_b == '0 && cmp_a == '0 && cmp_b == '0)); // R1

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (sel_a != 2'b11) && (sel_b != 2'b11)); // R2

  AST_OPND_A_EM: assert property (@(posedge clk) disable iff (rst)
    (sel_a == 2'b10) |=> (opnd_a == $past(em_val))); // R2

  AST_OPND_B_MW: assert property (@(posedge clk) disable iff (rst)
    (sel_b == 2'b01) |=> (opnd_b == $past(mw_val))); // R2

  AST_NO_WRITER: assert property (@(posedge clk) disable iff (rst)
    (!em_we && !mw_we) |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R3

  AST_ZERO_DEST: assert property (@(posedge clk) disable iff (rst)
    (em_rd == '0 && mw_rd == '0) |-> (sel_a == 2'b00 && sel_b == 2'b00 && !sel_c && !sel_d)); // R4

  AST_EM_WINS: assert property (@(posedge clk) disable iff (rst)
    (em_we && em_rd != '0 && em_rd == ex_rs) |-> (sel_a == 2'b10)); // R5

  AST_NO_BRANCH: assert property (@(posedge clk) disable iff (rst)
    !id_branch |-> (!sel_c && !sel_d)); // R7

  AST_CMP_EM: assert property (@(posedge clk) disable iff (rst)
    sel_c |=> (cmp_a == $past(em_val))); // R8
endmodule

bind fwd_unit_top fwd_unit_top_chk #(.REG_W(REG_W), .DATA_W(DATA_W)) chk_i (
  .clk(clk), .rst(rst), .ex_rs(ex_rs), .ex_rt(ex_rt), .em_rd(em_rd),
  .em_we(em_we), .mw_rd(mw_rd), .mw_we(mw_we), .id_branch(id_branch),
  .em_val(em_val), .mw_val(mw_val), .sel_a(sel_a), .sel_b(sel_b),
  .sel_c(sel_c), .sel_d(sel_d), .opnd_a(opnd_a), .opnd_b(opnd_b),
  .cmp_a(cmp_a), .cmp_b(cmp_b)
);

// File: tb/fwd_unit_top_tb_top.sv
module fwd_unit_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  localparam logic [31:0] V_DXA = 32'h1111_1111;
  localparam logic [31:0] V_DXB = 32'h2222_2222;
  localparam logic [31:0] V_EM  = 32'hAAAA_AAAA;
  localparam logic [31:0] V_MW  = 32'h5555_5555;
  localparam logic [31:0] V_IDA = 32'h3333_3333;
  localparam logic [31:0] V_IDB = 32'h4444_4444;

  typedef struct packed {
    logic [4:0] rs;
    logic [4:0] rt;
    logic [4:0] emrd;
    logic       emwe;
    logic [4:0] mwrd;
    logic       mwwe;
    logic [1:0] ea;
    logic [1:0] eb;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{5'd1,  5'd2,  5'd3,  1'b1, 5'd4,  1'b1, 2'b00, 2'b00}, // R3 no match
    '{5'd5,  5'd6,  5'd5,  1'b1, 5'd7,  1'b1, 2'b10, 2'b00}, // R3 em on A
    '{5'd5,  5'd6,  5'd8,  1'b1, 5'd6,  1'b1, 2'b00, 2'b01}, // R3 mw on B
    '{5'd9,  5'd9,  5'd9,  1'b1, 5'd9,  1'b1, 2'b10, 2'b10}, // R5 back-to-back
    '{5'd9,  5'd3,  5'd9,  1'b0, 5'd9,  1'b1, 2'b01, 2'b00}, // R5 em not writing
    '{5'd9,  5'd3,  5'd9,  1'b0, 5'd4,  1'b0, 2'b00, 2'b00}, // R3 non-writer match
    '{5'd0,  5'd0,  5'd0,  1'b1, 5'd0,  1'b1, 2'b00, 2'b00}, // R4 reg zero
    '{5'd0,  5'd7,  5'd0,  1'b1, 5'd7,  1'b1, 2'b00, 2'b01}, // R4 zero on A only
    '{5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1, 2'b10, 2'b01}, // R6 both, mixed
    '{5'd12, 5'd13, 5'd13, 1'b1, 5'd12, 1'b1, 2'b01, 2'b10}, // R6 both, swapped
    '{5'd14, 5'd15, 5'd3,  1'b1, 5'd14, 1'b0, 2'b00, 2'b00}  // R3 mw non-writer
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [4:0] ex_rs = '0, ex_rt = '0, em_rd = '0, mw_rd = '0, id_rs = '0, id_rt = '0;
  logic em_we = 1'b0, mw_we = 1'b0, id_branch = 1'b0;
  logic [1:0] sel_a, sel_b;
  logic sel_c, sel_d;
  logic [31:0] opnd_a, opnd_b, cmp_a, cmp_b;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_unit_top dut_i (
    .clk(clk), .rst(rst), .ex_rs(ex_rs), .ex_rt(ex_rt), .em_rd(em_rd),
    .em_we(em_we), .mw_rd(mw_rd), .mw_we(mw_we), .id_branch(id_branch),
    .id_rs(id_rs), .id_rt(id_rt), .ex_rs_val(V_DXA), .ex_rt_val(V_DXB),
    .em_val(V_EM), .mw_val(V_MW), .id_rs_val(V_IDA), .id_rt_val(V_IDB),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c), .sel_d(sel_d),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cmp_a(cmp_a), .cmp_b(cmp_b)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pick(input logic [1:0] s, input logic [31:0] dx);
    case (s)
      2'b10:   return V_EM;
      2'b01:   return V_MW;
      default: return dx;
    endcase
  endfunction

  task automatic settle();
    @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    // reset with a forwarding pattern present on the inputs
    em_rd = 5'd5; em_we = 1'b1; ex_rs = 5'd5;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 opnd_a", opnd_a, 32'h0);
    chk("R1 opnd_b", opnd_b, 32'h0);
    chk("R1 cmp_a", cmp_a, 32'h0);
    @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ex_rs = VECS[i].rs;   ex_rt = VECS[i].rt;
      em_rd = VECS[i].emrd; em_we = VECS[i].emwe;
      mw_rd = VECS[i].mwrd; mw_we = VECS[i].mwwe;
      #1;
      chk($sformatf("R3/R4/R5/R6 sel_a vec%0d", i), {30'b0, sel_a}, {30'b0, VECS[i].ea});
      chk($sformatf("R3/R4/R5/R6 sel_b vec%0d", i), {30'b0, sel_b}, {30'b0, VECS[i].eb});
      settle();
      chk($sformatf("R2 opnd_a vec%0d", i), opnd_a, pick(VECS[i].ea, V_DXA));
      chk($sformatf("R2 opnd_b vec%0d", i), opnd_b, pick(VECS[i].eb, V_DXB));
    end

    // R7/R8: branch with both sources produced by memory stage
    @(negedge clk);
    id_branch = 1'b1; id_rs = 5'd6; id_rt = 5'd6;
    em_rd = 5'd6; em_we = 1'b1; mw_rd = 5'd0; mw_we = 1'b0;
    #1;
    chk("R7 sel_c hit", {31'b0, sel_c}, 32'd1);
    chk("R7 sel_d hit", {31'b0, sel_d}, 32'd1);
    settle();
    chk("R8 cmp_a em", cmp_a, V_EM);
    chk("R8 cmp_b em", cmp_b, V_EM);

    // R7: no branch in decode
    @(negedge clk);
    id_branch = 1'b0;
    #1;
    chk("R7 sel_c no branch", {31'b0, sel_c}, 32'd0);
    settle();
    chk("R8 cmp_a decode value", cmp_a, V_IDA);

    // R7: register zero on the comparator path
    @(negedge clk);
    id_branch = 1'b1; id_rs = 5'd0; id_rt = 5'd8; em_rd = 5'd0;
    #1;
    chk("R7 sel_c zero", {31'b0, sel_c}, 32'd0);
    chk("R7 sel_d zero", {31'b0, sel_d}, 32'd0);

    // R9: writeback match does not reach the comparator
    @(negedge clk);
    id_rs = 5'd12; id_rt = 5'd13; em_rd = 5'd3; em_we = 1'b1;
    mw_rd = 5'd12; mw_we = 1'b1;
    #1;
    chk("R9 sel_c", {31'b0, sel_c}, 32'd0);
    settle();
    chk("R9 cmp_a", cmp_a, V_IDA);
    chk("R9 cmp_b", cmp_b, V_IDB);

    // R1: reset mid-run overrides an active forward
    @(negedge clk);
    ex_rs = 5'd3; rst = 1'b1;
    settle();
    chk("R1 opnd_a mid-run", opnd_a, 32'h0);
    @(negedge clk);
    rst = 1'b0;
    settle();
    chk("R2 opnd_a after reset", opnd_a, V_EM);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule